// File: doc/BRIEF.md
# Bank Activate Rate Limiter

This block sits between the command scheduler of a DDR2-class memory controller and the command bus. It tells the scheduler, every clock cycle, whether a row activate to any bank may go out now. It enforces two limits. The first is a minimum spacing between two successive activates. The second is a rolling cap: at most four activates may fall inside any window of a fixed length. Both limits are fixed in nanoseconds, whatever the speed grade. Parameters give them in picoseconds, together with the clock period, and they become whole clock counts at elaboration, always rounded up.

The scheduler raises `req_i` while it holds an activate ready. It sends the command in a cycle where `grant_o` is high, and marks that cycle with `issue_i`. Every `issue_i` is recorded, including one sent without a grant. A parameter selects the limit set for the organisation:
- wide (x16) parts use 10 ns spacing and a 50 ns window;
- narrow (x4/x8) parts use 7.5 ns spacing and a 37.5 ns window.

Spacing is tracked by a down-counter, which is reloaded on each issue. The window is tracked by a ring of four down-counters. Each issue reloads the oldest entry, and the ring pointer then moves on.

A four-state machine summarises the counters for the cycle ahead:
- `ST_IDLE`: no history.
- `ST_GAP`: the spacing counter is running.
- `ST_FULL`: spacing has elapsed, but the oldest window entry is still live.
- `ST_OPEN`: history exists, but nothing blocks.

At every edge the machine moves to the state that the counters' next values select. The priority is `ST_GAP`, then `ST_FULL`, then `ST_IDLE`, then `ST_OPEN`. Reset enters `ST_IDLE`. The grant follows `req_i` in `ST_IDLE` and `ST_OPEN`, and is low in `ST_GAP` and `ST_FULL`.

Top module: `act_rate_limiter`

## Requirements
- R1: After reset, all history is cleared, so `grant_o` equals `req_i` in the first cycle after reset is released.
- R2: After an issue in cycle t, `grant_o` is low in cycles t+1 to t+GAP-1, where GAP is the spacing in clocks. The spacing limit allows a grant again from cycle t+GAP.
- R3: An activate in cycle t would be the fifth of a run if four issues came before it. In that case `grant_o` is low unless t is at least FAW clocks after the earliest of those four.
- R4: Each limit in clocks is ceil(limit_ps / CLK_PS). Wide parts at CLK_PS=5000 give GAP=2 and FAW=10. Narrow parts at CLK_PS=3000 give GAP=3 and FAW=13.
- R5: WIDE_ORG=1 selects the 10000 ps spacing and the 50000 ps window. WIDE_ORG=0 selects the 7500 ps spacing and the 37500 ps window.
- R6: `grant_o` is low in every cycle where `req_i` is low.
- R7: `grant_o` depends only on the stored history and `req_i`. In the cycle an activate is issued, the grant shows the state before that issue. A blocking state applies from the next cycle.
- R8: Under back-to-back issuing, the window slides. As soon as the oldest of the last four issues is FAW clocks old, one more activate is granted.
- R9: Issues spaced at least FAW clocks apart are never blocked. The grant equals `req_i` in every cycle.
- R10: An issue strobe sent while `req_i` is low is still recorded, and it restarts the spacing and window limits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears all history |
| req_i | input | 1 | Scheduler holds an activate ready this cycle |
| issue_i | input | 1 | An activate is sent on the bus this cycle |
| grant_o | output | 1 | An activate may be sent this cycle |

## Verification
Two instances run at the same time and are compared, cycle by cycle, with a timestamp model of the two rules:
- a wide-organisation instance at 5000 ps;
- a narrow-organisation instance at 3000 ps, where both limits need rounding up.

Greedy issuing, which sends an activate whenever the model allows it, separates the pairwise spacing from the four-in-a-window cap, and shows whether the window slides or only resets. Sparse issuing, spaced beyond the window, shows that history which has expired never blocks. A hidden issue sent with the request low, and a reset in the middle of the run, show that the history is kept, and then cleared.

// File: rtl/act_rl_pkg.sv
package act_rl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_GAP  = 2'd1,
        ST_FULL = 2'd2,
        ST_OPEN = 2'd3
    } act_state_e;

    localparam int GAP_PS_NARROW = 7500;
    localparam int GAP_PS_WIDE   = 10000;
    localparam int WIN_PS_NARROW = 37500;
    localparam int WIN_PS_WIDE   = 50000;

    // Round a picosecond limit up to whole clocks, never below one.
    function automatic int ps_to_cyc(input int ps, input int clk_ps);
        int c;
        c = (ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/act_gap_timer.sv
module act_gap_timer #(
    parameter int GAP_CYC = 2,
    parameter int GW      = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic issue_i,
    output logic busy_next_o
);
    localparam logic [GW-1:0] LOAD = GW'(GAP_CYC - 1);

    logic [GW-1:0] cnt_q;
    logic [GW-1:0] cnt_d;

    always_comb begin
        if (issue_i) begin
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_next_o = (cnt_d != '0);

endmodule

// File: rtl/act_window_track.sv
module act_window_track #(
    parameter int WIN_N   = 4,
    parameter int WIN_CYC = 10,
    parameter int CW      = 4,
    parameter int PW      = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic issue_i,
    output logic full_next_o,
    output logic empty_next_o
);
    localparam logic [CW-1:0] LOAD    = CW'(WIN_CYC - 1);
    localparam logic [PW-1:0] PTR_TOP = PW'(WIN_N - 1);

    logic [PW-1:0]  ptr_q, ptr_d;
    logic [CW-1:0]  age_q [WIN_N];
    logic [CW-1:0]  age_d [WIN_N];
    logic [WIN_N-1:0] live_d;

    always_comb begin
        if (!issue_i) begin
            ptr_d = ptr_q;
        end else if (ptr_q == PTR_TOP) begin
            ptr_d = '0;
        end else begin
            ptr_d = ptr_q + 1'b1;
        end
    end

    for (genvar g = 0; g < WIN_N; g++) begin : g_slot
        always_comb begin
            if (issue_i && (ptr_q == PW'(g))) begin
                age_d[g] = LOAD;
            end else if (age_q[g] != '0) begin
                age_d[g] = age_q[g] - 1'b1;
            end else begin
                age_d[g] = '0;
            end
        end

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                age_q[g] <= '0;
            end else begin
                age_q[g] <= age_d[g];
            end
        end

        assign live_d[g] = (age_d[g] != '0);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else begin
            ptr_q <= ptr_d;
        end
    end

    // The slot the pointer will rest on next is the oldest entry.
    assign full_next_o  = live_d[ptr_d];
    assign empty_next_o = ~|live_d;

endmodule

// File: rtl/act_grant_fsm.sv
module act_grant_fsm
    import act_rl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic gap_busy_next_i,
    input  logic full_next_i,
    input  logic empty_next_i,
    input  logic req_i,
    output logic grant_o
);
    act_state_e state_q, state_d;

    always_comb begin
        if (gap_busy_next_i) begin
            state_d = ST_GAP;
        end else if (full_next_i) begin
            state_d = ST_FULL;
        end else if (empty_next_i) begin
            state_d = ST_IDLE;
        end else begin
            state_d = ST_OPEN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        grant_o = 1'b0;
        unique case (state_q)
            ST_IDLE: grant_o = req_i;
            ST_OPEN: grant_o = req_i;
            ST_GAP:  grant_o = 1'b0;
            ST_FULL: grant_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/act_rate_limiter.sv
module act_rate_limiter
    import act_rl_pkg::*;
#(
    parameter int CLK_PS   = 5000,
    parameter bit WIDE_ORG = 1'b1,
    parameter int WIN_N    = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic issue_i,
    output logic grant_o
);
    localparam int GAP_PS  = WIDE_ORG ? GAP_PS_WIDE : GAP_PS_NARROW;
    localparam int WIN_PS  = WIDE_ORG ? WIN_PS_WIDE : WIN_PS_NARROW;
    localparam int GAP_CYC = ps_to_cyc(GAP_PS, CLK_PS);
    localparam int WIN_CYC = ps_to_cyc(WIN_PS, CLK_PS);
    localparam int GW      = $clog2(GAP_CYC + 1);
    localparam int CW      = $clog2(WIN_CYC + 1);
    localparam int PW      = (WIN_N > 1) ? $clog2(WIN_N) : 1;

    logic gap_busy_next;
    logic full_next;
    logic empty_next;

    act_gap_timer #(
        .GAP_CYC(GAP_CYC),
        .GW     (GW)
    ) gap_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .issue_i    (issue_i),
        .busy_next_o(gap_busy_next)
    );

    act_window_track #(
        .WIN_N  (WIN_N),
        .WIN_CYC(WIN_CYC),
        .CW     (CW),
        .PW     (PW)
    ) win_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .issue_i     (issue_i),
        .full_next_o (full_next),
        .empty_next_o(empty_next)
    );

    act_grant_fsm fsm_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .gap_busy_next_i(gap_busy_next),
        .full_next_i    (full_next),
        .empty_next_i   (empty_next),
        .req_i          (req_i),
        .grant_o        (grant_o)
    );

endmodule

// File: rtl/act_rate_checker.sv
module act_rate_checker #(
    parameter int GAP_CYC = 2,
    parameter int WIN_CYC = 10,
    parameter int WIN_N   = 4
) (
    input logic clk_i,
    input logic rst_ni,
    input logic req_i,
    input logic issue_i,
    input logic grant_o
);
    localparam int GW = $clog2(GAP_CYC + 1);
    localparam int CW = $clog2(WIN_CYC + 1);
    localparam int PW = (WIN_N > 1) ? $clog2(WIN_N) : 1;
    localparam logic [GW-1:0] GAP_SAT = GW'(GAP_CYC);
    localparam logic [CW-1:0] WIN_SAT = CW'(WIN_CYC);
    localparam logic [PW-1:0] PTR_TOP = PW'(WIN_N - 1);

    // Elapsed cycles since the last issue, and since each of the last N issues.
    logic [GW-1:0] since_q;
    logic [CW-1:0] elapsed_q [WIN_N];
    logic [PW-1:0] ring_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_q <= GAP_SAT;
            ring_q  <= '0;
            for (int k = 0; k < WIN_N; k++) elapsed_q[k] <= WIN_SAT;
        end else begin
            if (issue_i) begin
                since_q <= GW'(1);
            end else if (since_q < GAP_SAT) begin
                since_q <= since_q + 1'b1;
            end
            for (int k = 0; k < WIN_N; k++) begin
                if (issue_i && (ring_q == PW'(k))) begin
                    elapsed_q[k] <= CW'(1);
                end else if (elapsed_q[k] < WIN_SAT) begin
                    elapsed_q[k] <= elapsed_q[k] + 1'b1;
                end
            end
            if (issue_i) ring_q <= (ring_q == PTR_TOP) ? '0 : ring_q + 1'b1;
        end
    end

    a_r2_gap_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_q < GAP_SAT) |-> !grant_o);

    a_r3_window_respected: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (elapsed_q[ring_q] < WIN_SAT) |-> !grant_o);

    a_r6_no_grant_without_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |-> !grant_o);

    a_r8_grant_when_free: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((since_q >= GAP_SAT) && (elapsed_q[ring_q] >= WIN_SAT)) |-> (grant_o == req_i));

    a_r1_open_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (grant_o == req_i));

endmodule

bind act_rate_limiter act_rate_checker #(
    .GAP_CYC(GAP_CYC),
    .WIN_CYC(WIN_CYC),
    .WIN_N  (WIN_N)
) chk_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .issue_i(issue_i),
    .grant_o(grant_o)
);

// File: tb/act_rate_limiter_tb_top.sv
`timescale 1ns/1ps
module act_rate_limiter_tb_top;

    // R4 / R5: expected clock limits worked out by hand.
    localparam int W_GAP = 2;   // 10000 ps / 5000 ps
    localparam int W_FAW = 10;  // 50000 ps / 5000 ps
    localparam int N_GAP = 3;   // 7500 ps / 3000 ps, rounded up
    localparam int N_FAW = 13;  // 37500 ps / 3000 ps, rounded up

    typedef struct {
        int    unit;
        bit    exp;
        string tag;
        int    cyc;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic req = 1'b0;
    logic iss_w = 1'b0;
    logic iss_n = 1'b0;
    logic grant_w, grant_n;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    int hist_w[$];
    int hist_n[$];
    sb_item_t sb[$];

    always #2.5 clk = ~clk;

    act_rate_limiter #(.CLK_PS(5000), .WIDE_ORG(1'b1), .WIN_N(4)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .issue_i(iss_w), .grant_o(grant_w));

    act_rate_limiter #(.CLK_PS(3000), .WIDE_ORG(1'b0), .WIN_N(4)) dut_n_i (
        .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .issue_i(iss_n), .grant_o(grant_n));

    function automatic bit allowed(input int h[$], input int c, input int gap, input int faw);
        bit ok;
        ok = 1'b1;
        if (h.size() > 0 && (c - h[h.size()-1]) < gap) ok = 1'b0;
        if (h.size() >= 4 && (c - h[h.size()-4]) < faw) ok = 1'b0;
        return ok;
    endfunction

    // Driver: greedy issues follow the model's grant; otherwise the given value is used.
    task automatic drive(input bit rq, input bit greedy, input bit fixed_iss, input string tag);
        bit ew, en;
        sb_item_t it;
        @(negedge clk);
        ew = rq && allowed(hist_w, cyc, W_GAP, W_FAW);
        en = rq && allowed(hist_n, cyc, N_GAP, N_FAW);
        req   = rq;
        iss_w = greedy ? ew : fixed_iss;
        iss_n = greedy ? en : fixed_iss;
        #1;
        it.unit = 0; it.exp = ew; it.tag = tag; it.cyc = cyc; sb.push_back(it);
        it.unit = 1; it.exp = en; sb.push_back(it);
        if (iss_w) hist_w.push_back(cyc);
        if (iss_n) hist_n.push_back(cyc);
        cyc++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        req = 1'b0; iss_w = 1'b0; iss_n = 1'b0;
        repeat (3) @(negedge clk);
        hist_w.delete();
        hist_n.delete();
        rst_ni = 1'b1;
    endtask

    // Monitor: compares each expected item once the outputs have settled.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0) begin
                sb_item_t it;
                logic act;
                it = sb.pop_front();
                act = (it.unit == 0) ? grant_w : grant_n;
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s unit=%0d cycle=%0d grant actual=%b expected=%b",
                             it.tag, it.unit, it.cyc, act, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R6: no request, so no grant, right after reset.
        drive(1'b0, 1'b0, 1'b0, "R6");
        // R1: the first request after reset is granted immediately.
        drive(1'b1, 1'b1, 1'b0, "R1");
        // R2 R3 R7 R8 R4 R5: greedy stream covering spacing and sliding window.
        for (int i = 0; i < 60; i++) drive(1'b1, 1'b1, 1'b0, "R3");
        // Let all history expire.
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, 1'b0, "R6");
        // R10: a hidden issue with req low must still block the next cycles.
        drive(1'b0, 1'b0, 1'b1, "R10");
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, "R10");
        for (int i = 0; i < 20; i++) drive(1'b0, 1'b0, 1'b0, "R6");
        // R9: sparse issues beyond the window are never held back.
        for (int k = 0; k < 6; k++) begin
            drive(1'b1, 1'b1, 1'b0, "R9");
            for (int i = 0; i < 14; i++) drive(1'b1, 1'b0, 1'b0, "R9");
        end
        // R2: a fast burst, then a reset in the middle of blocking.
        for (int i = 0; i < 7; i++) drive(1'b1, 1'b1, 1'b0, "R2");
        do_reset();
        cyc = 0;
        // R1: history cleared by the reset.
        drive(1'b1, 1'b1, 1'b0, "R1");
        for (int i = 0; i < 40; i++) drive(1'b1, 1'b1, 1'b0, "R8");
        drive(1'b0, 1'b0, 1'b0, "R6");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule